// File: doc/BRIEF.md
# Staircase Ramp Generator

The block drives a 12-bit code that climbs or falls in fixed increments from a programmed start value toward a programmed end value. Four configuration slots are held side by side. Each slot has a start value, an end value, an increment of 0 to 15, a direction bit and a repeat bit, and each slot has its own trigger input.

A trigger arms the chosen slot. After that, every pulse on the advance strobe, which comes from an external pacing unit, moves the output by one stair. When the ramp reaches its end value, a sticky completion flag is set. The flag is cleared by driving 1 on the clear input. It can raise an interrupt line when the interrupt enable is high.

In repeat mode, the advance after the end value loads the start value again and the ramp runs once more. Otherwise the output stays at the end value until a new trigger arrives.

Top module: `stair_ramp`

## Requirements
- R1: While `rst_n` is low and after reset, `level_o` is 0 and both `done_flag_o` and `irq_o` are 0.
- R2: A trigger seen while the block is idle arms that slot without changing `level_o`. The first advance after that loads the slot's start value onto `level_o`.
- R3: With direction 0 (up), each later advance adds the slot increment to `level_o`.
- R4: With direction 1 (down), each later advance subtracts the slot increment from `level_o`.
- R5: An advance that would reach or pass the end value sets `level_o` to exactly the end value and sets `done_flag_o` in the same clock.
- R6: An increment of 0 keeps `level_o` at the start value on every advance and never sets the completion flag.
- R7: With repeat bit 0, advances after the end has been reached leave `level_o` at the end value.
- R8: With repeat bit 1, the advance after the end loads the start value again, the ramp runs again, and `done_flag_o` is set again each time the end is reached.
- R9: When several trigger bits are high at once while idle, the slot with the lowest index wins (bit 0 is slot 0).
- R10: Triggers that arrive while a ramp is armed or running have no effect on `level_o`.
- R11: `done_flag_o` stays set until a clock in which `done_clr_i` is 1, and it is 0 after that clock. A completion in the same clock as a clear leaves the flag set.
- R12: `irq_o` is high exactly when `done_flag_o` and `irq_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_start_i | input | 48 | Start values, slot k in bits [12k+11:12k] |
| slot_end_i | input | 48 | End values, slot k in bits [12k+11:12k] |
| slot_inc_i | input | 16 | Increments, slot k in bits [4k+3:4k] |
| slot_down_i | input | 4 | Direction per slot, 1 = down |
| slot_loop_i | input | 4 | Repeat bit per slot, 1 = reload and repeat |
| trig_i | input | 4 | Trigger per slot, sampled while idle |
| advance_i | input | 1 | One-cycle strobe that moves the ramp by one stair |
| done_clr_i | input | 1 | Write-one-to-clear for the completion flag |
| irq_en_i | input | 1 | Interrupt enable for the completion flag |
| level_o | output | 12 | Ramp output code |
| done_flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Completion interrupt |

## Verification
The properties assume that the configuration of the active slot stays constant while that slot is armed or running. The monotonic-step checks rely on this, because they compare against the live end value. They also assume that `advance_i` is a single-clock pulse. The stimulus writes each slot's fields only while the block is in reset or idle and never changes them during a ramp. Every advance strobe lasts exactly one clock, with at least one clock low between strobes.

// File: rtl/ramp_pkg.sv
// Shared types for the staircase ramp generator.
package ramp_pkg;
    // Sequencer state: waiting for a trigger, armed (next advance loads
    // the start value), or stepping toward the end value.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ramp_state_e;
endpackage

// File: rtl/ramp_slot_pick.sv
// Slot selection: a priority encoder that picks the lowest-numbered
// requesting trigger, and a multiplexer that presents the fields of
// the latched slot. Assumes NSLOT >= 2.
module ramp_slot_pick #(
    parameter int NSLOT = 4,
    parameter int W     = 12,
    parameter int IW    = 4,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic [NSLOT*W-1:0]  slot_start_i,
    input  logic [NSLOT*W-1:0]  slot_end_i,
    input  logic [NSLOT*IW-1:0] slot_inc_i,
    input  logic [NSLOT-1:0]    slot_down_i,
    input  logic [NSLOT-1:0]    slot_loop_i,
    input  logic [NSLOT-1:0]    trig_i,
    input  logic [SW-1:0]       sel_i,
    output logic                req_any_o,
    output logic [SW-1:0]       req_idx_o,
    output logic [W-1:0]        cur_start_o,
    output logic [W-1:0]        cur_end_o,
    output logic [IW-1:0]       cur_inc_o,
    output logic                cur_down_o,
    output logic                cur_loop_o
);
    logic [W-1:0]  start_a [NSLOT];
    logic [W-1:0]  end_a   [NSLOT];
    logic [IW-1:0] inc_a   [NSLOT];

    // Split the flat configuration vectors into per-slot fields.
    for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
        assign start_a[g] = slot_start_i[g*W +: W];
        assign end_a[g]   = slot_end_i[g*W +: W];
        assign inc_a[g]   = slot_inc_i[g*IW +: IW];
    end

    // Lowest-index request wins: scan from the top down so lower bits overwrite.
    always_comb begin
        req_any_o = |trig_i;
        req_idx_o = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (trig_i[k]) req_idx_o = k[SW-1:0];
        end
    end

    // Present the fields of the latched slot.
    always_comb begin
        cur_start_o = start_a[sel_i];
        cur_end_o   = end_a[sel_i];
        cur_inc_o   = inc_a[sel_i];
        cur_down_o  = slot_down_i[sel_i];
        cur_loop_o  = slot_loop_i[sel_i];
    end
endmodule

// File: rtl/ramp_next.sv
// Next-stair arithmetic: adds or subtracts the increment and clamps to
// the end value when the step would reach or pass it, including a
// borrow below zero. Purely combinational.
module ramp_next #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input  logic [W-1:0]  level_i,
    input  logic [W-1:0]  end_i,
    input  logic [IW-1:0] inc_i,
    input  logic          down_i,
    output logic [W-1:0]  next_o,
    output logic          hit_o
);
    logic [W:0] inc_ext;
    logic [W:0] sum;
    logic [W:0] diff;

    // Widen by one bit so carry and borrow are visible.
    always_comb begin
        inc_ext = {{(W+1-IW){1'b0}}, inc_i};
        sum     = {1'b0, level_i} + inc_ext;
        diff    = {1'b0, level_i} - inc_ext;
        if (down_i) begin
            hit_o  = diff[W] || (diff[W-1:0] <= end_i);
            next_o = hit_o ? end_i : diff[W-1:0];
        end else begin
            hit_o  = (sum >= {1'b0, end_i});
            next_o = hit_o ? end_i : sum[W-1:0];
        end
    end
endmodule

// File: rtl/ramp_done_flag.sv
// Sticky completion flag with write-one-to-clear and an interrupt gate.
// A set in the same cycle as a clear wins.
module ramp_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    // Hold the flag until it is cleared; a new completion has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= set_i | (flag_o & ~clr_i);
    end

    // Interrupt follows the flag while enabled.
    assign irq_o = flag_o & en_i;
endmodule

// File: rtl/stair_ramp.sv
// Staircase ramp generator top. Latches a triggered slot, loads its start
// value on the first advance, then steps by its increment on each later
// advance until the end value, then stops or repeats. Assumes the active
// slot's configuration is held constant while armed or running.
module stair_ramp #(
    parameter int NSLOT = 4,
    parameter int W     = 12,
    parameter int IW    = 4,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT*W-1:0]  slot_start_i,
    input  logic [NSLOT*W-1:0]  slot_end_i,
    input  logic [NSLOT*IW-1:0] slot_inc_i,
    input  logic [NSLOT-1:0]    slot_down_i,
    input  logic [NSLOT-1:0]    slot_loop_i,
    input  logic [NSLOT-1:0]    trig_i,
    input  logic                advance_i,
    input  logic                done_clr_i,
    input  logic                irq_en_i,
    output logic [W-1:0]        level_o,
    output logic                done_flag_o,
    output logic                irq_o
);
    import ramp_pkg::*;

    ramp_state_e   state;
    logic [SW-1:0] slot_q;
    logic          req_any;
    logic [SW-1:0] req_idx;
    logic [W-1:0]  cur_start;
    logic [W-1:0]  cur_end;
    logic [IW-1:0] cur_inc;
    logic          cur_down;
    logic          cur_loop;
    logic [W-1:0]  step_val;
    logic          step_hit;
    logic          running;
    logic          step_done;

    ramp_slot_pick #(.NSLOT(NSLOT), .W(W), .IW(IW)) u_pick (
        .slot_start_i (slot_start_i),
        .slot_end_i   (slot_end_i),
        .slot_inc_i   (slot_inc_i),
        .slot_down_i  (slot_down_i),
        .slot_loop_i  (slot_loop_i),
        .trig_i       (trig_i),
        .sel_i        (slot_q),
        .req_any_o    (req_any),
        .req_idx_o    (req_idx),
        .cur_start_o  (cur_start),
        .cur_end_o    (cur_end),
        .cur_inc_o    (cur_inc),
        .cur_down_o   (cur_down),
        .cur_loop_o   (cur_loop)
    );

    ramp_next #(.W(W), .IW(IW)) u_next (
        .level_i (level_o),
        .end_i   (cur_end),
        .inc_i   (cur_inc),
        .down_i  (cur_down),
        .next_o  (step_val),
        .hit_o   (step_hit)
    );

    assign running   = (state == ST_RUN);
    // Completion: a non-zero step that lands on the end value.
    assign step_done = running && advance_i && (cur_inc != '0) && step_hit;

    // Sequencer: latch the slot, load the start value, step, stop or repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            slot_q  <= '0;
            level_o <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_any) begin
                        slot_q <= req_idx;
                        state  <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (advance_i) begin
                        level_o <= cur_start;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (advance_i && (cur_inc != '0)) begin
                        level_o <= step_val;
                        if (step_hit) state <= cur_loop ? ST_ARMED : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ramp_done_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (step_done),
        .clr_i  (done_clr_i),
        .en_i   (irq_en_i),
        .flag_o (done_flag_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/stair_ramp_chk.sv
// Temporal checks on the ramp generator, attached by bind.
module stair_ramp_chk #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          advance_i,
    input logic          done_clr_i,
    input logic [W-1:0]  level_o,
    input logic          done_flag_o,
    input logic          running,
    input logic          step_done,
    input logic [W-1:0]  cur_end,
    input logic [IW-1:0] cur_inc,
    input logic          cur_down
);
    // R2: the output only moves on an advance.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(level_o));

    // R3: an upward step never lowers the output below the end.
    p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running && advance_i && !cur_down && level_o <= cur_end |=> level_o >= $past(level_o));

    // R4: a downward step never raises the output above the end.
    p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running && advance_i && cur_down && level_o >= cur_end |=> level_o <= $past(level_o));

    // R5: on completion the output equals the end value.
    p_end_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> level_o == $past(cur_end) && done_flag_o);

    // R6: a zero increment freezes the output while running.
    p_zero_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running && advance_i && cur_inc == '0 |=> $stable(level_o));

    // R11: the flag is sticky without a clear.
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag_o && !done_clr_i |=> done_flag_o);

    // R11: a clear without a new completion drops the flag.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_clr_i && !step_done |=> !done_flag_o);
endmodule

bind stair_ramp stair_ramp_chk #(.W(W), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance_i   (advance_i),
    .done_clr_i  (done_clr_i),
    .level_o     (level_o),
    .done_flag_o (done_flag_o),
    .running     (running),
    .step_done   (step_done),
    .cur_end     (cur_end),
    .cur_inc     (cur_inc),
    .cur_down    (cur_down)
);

// File: tb/sim_stair_ramp.sv
module sim_stair_ramp;
    localparam int NS = 4;
    localparam int W  = 12;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [NS*W-1:0]  st = '0;
    logic [NS*W-1:0]  en = '0;
    logic [NS*IW-1:0] inc = '0;
    logic [NS-1:0]    dn = '0;
    logic [NS-1:0]    lp = '0;
    logic [NS-1:0]    trig = '0;
    logic             advance = 1'b0;
    logic             clr = 1'b0;
    logic             irq_en = 1'b0;
    logic [W-1:0]     level;
    logic             flag;
    logic             irq;

    stair_ramp u0 (
        .clk(clk), .rst_n(rst_n),
        .slot_start_i(st), .slot_end_i(en), .slot_inc_i(inc),
        .slot_down_i(dn), .slot_loop_i(lp), .trig_i(trig),
        .advance_i(advance), .done_clr_i(clr), .irq_en_i(irq_en),
        .level_o(level), .done_flag_o(flag), .irq_o(irq)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct { logic [W-1:0] lvl; string tag; } exp_t;
    exp_t q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: after each advance edge, compare the output with the queue head.
    always @(posedge clk) begin
        if (advance && rst_n) begin
            @(negedge clk);
            checks++;
            if (q.size() == 0) begin
                errs++;
                $display("FAIL scoreboard actual=%0d expected=<none>", level);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (level !== e.lvl) begin
                    errs++;
                    $display("FAIL %s actual=%0d expected=%0d", e.tag, level, e.lvl);
                end
            end
        end
    end

    // Driver: queue the expected level, then strobe one advance.
    task automatic adv(logic [W-1:0] e, string tag);
        @(negedge clk);
        q.push_back('{e, tag});
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic pulse_trig(logic [NS-1:0] t);
        @(negedge clk); trig = t;
        @(negedge clk); trig = '0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_slot(int k, logic [W-1:0] s, logic [W-1:0] e, logic [IW-1:0] i, logic d, logic l);
        st[k*W +: W]    = s;
        en[k*W +: W]    = e;
        inc[k*IW +: IW] = i;
        dn[k] = d;
        lp[k] = l;
    endtask

    initial begin
        set_slot(0, 12'd100, 12'd110, 4'd3, 1'b0, 1'b0);
        set_slot(1, 12'd200, 12'd190, 4'd4, 1'b1, 1'b1);
        set_slot(2, 12'd50,  12'd60,  4'd0, 1'b0, 1'b0);
        set_slot(3, 12'd0,   12'd2,   4'd2, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 level in reset", level, 0);
        chk("R1 flag in reset", flag, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level after reset", level, 0);

        // Slot 0 upward with clamping, then stop.
        pulse_trig(4'b0001);
        repeat (2) @(negedge clk);
        chk("R2 armed holds level", level, 0);
        adv(12'd100, "R2 first advance loads start");
        adv(12'd103, "R3 up step");
        pulse_trig(4'b0010);
        adv(12'd106, "R10 trigger during run ignored");
        adv(12'd109, "R3 up step");
        chk("R5 flag not set before end", flag, 0);
        adv(12'd110, "R5 clamp to end");
        chk("R5 flag set at end", flag, 1);
        adv(12'd110, "R7 held at end");
        adv(12'd110, "R7 held at end");
        chk("R11 flag sticky", flag, 1);
        irq_en = 1'b1; #1;
        chk("R12 irq with enable", irq, 1);
        irq_en = 1'b0; #1;
        chk("R12 irq masked", irq, 0);
        pulse_clr();
        chk("R11 flag cleared", flag, 0);
        irq_en = 1'b1; #1;
        chk("R12 irq after clear", irq, 0);
        irq_en = 1'b0;

        // Slot 1 downward, repeating.
        pulse_trig(4'b0010);
        adv(12'd200, "R4 load start");
        adv(12'd196, "R4 down step");
        adv(12'd192, "R4 down step");
        adv(12'd190, "R4 clamp to end");
        chk("R8 flag at first end", flag, 1);
        pulse_clr();
        adv(12'd200, "R8 reload start");
        adv(12'd196, "R8 second pass");
        adv(12'd192, "R8 second pass");
        chk("R8 flag clear mid pass", flag, 0);
        adv(12'd190, "R8 second end");
        chk("R8 flag set again", flag, 1);

        // Priority between simultaneous triggers.
        do_reset();
        pulse_trig(4'b0110);
        adv(12'd200, "R9 lowest slot wins");
        adv(12'd196, "R9 slot one direction");

        // Zero increment holds the start value.
        do_reset();
        pulse_trig(4'b0100);
        for (int i = 0; i < 4; i++) adv(12'd50, "R6 zero increment holds");
        chk("R6 no completion", flag, 0);

        // Completion in the same clock as a clear.
        do_reset();
        pulse_trig(4'b1000);
        adv(12'd0, "R2 load start slot three");
        @(negedge clk);
        q.push_back('{12'd2, "R5 end reached"});
        advance = 1'b1; clr = 1'b1;
        @(negedge clk);
        advance = 1'b0; clr = 1'b0;
        chk("R11 set wins over clear", flag, 1);
        pulse_clr();
        chk("R11 cleared afterwards", flag, 0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule